// File: doc/BRIEF.md
# Single-Cycle Carrier Period Detector

This block tells, one carrier period at a time, whether a digitized input toggles at the expected carrier rate. A fast reference clock times each gap between consecutive rising edges of the input. A gap of the right length raises a carrier-present flag. A gap that is too short lowers it. If the next edge is overdue, the flag drops and the detector disarms until another edge arrives.

The input is asynchronous. It is first brought into the reference domain, and its rising edges become one-clock pulses. Each pulse clears a small interval counter, and the counter then advances once per reference clock. When the next pulse arrives, the count held at that moment decides the verdict. With the default sizing, the reference clock runs at about 15.36 times the carrier rate. A valid carrier period is therefore 15 or 16 reference clocks from one detected edge to the next.

Top module: `carrier_period_detector`

## Requirements
- R1: While `rst_n` is low at a clock edge, `carrier_ok` is low after that edge, and the detector is left disarmed.
- R2: The input passes through two synchronizing flops and an edge register. A rising edge of `carrier_in` sampled at clock k is acted on at the clock edge k+2.
- R3: When an armed detector sees an edge 15 or 16 reference clocks after the previous edge, `carrier_ok` is high after that clock.
- R4: When an edge arrives 14 or fewer clocks after the previous edge, `carrier_ok` is low after that clock, and a fresh measurement starts from that edge.
- R5: When 16 clocks pass after an edge with no new edge, `carrier_ok` is low after the 16th clock.
- R6: After a timeout the detector stays disarmed. The first edge that follows leaves `carrier_ok` low and only restarts timing.
- R7: After reset, the first edge only starts a measurement and leaves `carrier_ok` low.
- R8: The verdict depends only on the spacing of rising edges. A one-clock high time and a fourteen-clock high time give the same result.
- R9: Once high, `carrier_ok` stays high across consecutive valid intervals. It falls only on a short interval or a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock used for timing |
| rst_n | input | 1 | Synchronous active-low reset |
| carrier_in | input | 1 | Asynchronous digitized carrier |
| carrier_ok | output | 1 | High while valid carrier periods are being seen |

## Verification
The bench targets both edges of the acceptance window. An interval of 14 clocks must read as too short, 15 and 16 must read as valid, and 17 must time out before the edge lands. An off-by-one comparison or an edge that takes priority over the timeout wrongly would flip one of these verdicts. It also replays the first edge after reset and after a timeout. A detector that reused a stale count would then raise the flag with no complete period. Bursts at 12- and 20-clock periods check that off-frequency input never produces a high output. Mixed duty cycles check that nothing depends on the high time.

// File: rtl/cpd_pkg.sv
// Shared sizing for the carrier period detector.
// Assumes the window upper bound is the counter's full-scale value.
package cpd_pkg;
    localparam int unsigned CPD_CNT_W      = 4;
    localparam int unsigned CPD_SYNC_DEPTH = 2;
    // Lowest count at the closing edge that is accepted as a valid period.
    localparam int unsigned CPD_WIN_LO     = (1 << CPD_CNT_W) - 2;
endpackage

// File: rtl/cpd_edge_sync.sv
// Brings the asynchronous carrier into the reference domain and emits a
// one-clock pulse on each rising edge.
// Assumes SYNC_DEPTH >= 2 and a synchronous active-low reset.
module cpd_edge_sync #(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic sig_async,
    output logic rise_p
);
    logic [SYNC_DEPTH-1:0] chain_q;
    logic                  prev_q;

    // Shift the raw input through the synchronizer chain.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_DEPTH-2:0], sig_async};
    end

    // Keep the last synchronized level for edge detection.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[SYNC_DEPTH-1];
    end

    // A rising edge is a synchronized high that follows a low.
    always_comb rise_p = chain_q[SYNC_DEPTH-1] & ~prev_q;
endmodule

// File: rtl/cpd_interval_timer.sv
// Times reference clocks since the last edge. It flags a closing edge inside
// the acceptance window and signals a timeout once the count is exhausted.
// Assumes the edge pulse is one clock wide. The count saturates and holds
// while disarmed.
module cpd_interval_timer #(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned WIN_LO = 14
) (
    input  logic             clk_ref,
    input  logic             rst_n,
    input  logic             rise_p,
    output logic             in_window,
    output logic             timeout_p,
    output logic             armed,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_LO  = CNT_W'(WIN_LO);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_max;

    // Full-scale count is the last one at which an edge is still on time.
    always_comb at_max = (cnt_q == CNT_MAX);

    // Clear the counter on an edge; advance while armed; hold at full scale.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)          cnt_q <= CNT_MAX;
        else if (rise_p)     cnt_q <= '0;
        else if (armed_q && !at_max) cnt_q <= cnt_q + 1'b1;
    end

    // Arm on every edge; disarm once full scale passes without an edge.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)                   armed_q <= 1'b0;
        else if (rise_p)              armed_q <= 1'b1;
        else if (armed_q && at_max)   armed_q <= 1'b0;
    end

    // Report the window and timeout conditions to the verdict stage.
    always_comb begin
        in_window = armed_q && (cnt_q >= CNT_LO);
        timeout_p = armed_q && at_max && !rise_p;
    end

    always_comb begin
        armed = armed_q;
        count = cnt_q;
    end
endmodule

// File: rtl/cpd_verdict.sv
// Holds the carrier-present flag. On an edge the flag takes the window
// result; a timeout clears it; otherwise it keeps its value.
// Assumes the edge and the timeout are never active together.
module cpd_verdict (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic rise_p,
    input  logic in_window,
    input  logic timeout_p,
    output logic present
);
    logic present_q;

    // Update the flag on each closing edge or on a timeout.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)         present_q <= 1'b0;
        else if (rise_p)    present_q <= in_window;
        else if (timeout_p) present_q <= 1'b0;
    end

    always_comb present = present_q;
endmodule

// File: rtl/carrier_period_detector.sv
// Top level: synchronizer and edge detector, interval timer, verdict flag.
// Assumes a free-running reference clock about 15.36 times the carrier rate.
module carrier_period_detector
    import cpd_pkg::*;
(
    input  logic clk_ref,
    input  logic rst_n,
    input  logic carrier_in,
    output logic carrier_ok
);
    logic                 rise_p;
    logic                 in_window;
    logic                 timeout_p;
    logic                 armed;
    logic [CPD_CNT_W-1:0] count;

    cpd_edge_sync #(.SYNC_DEPTH(CPD_SYNC_DEPTH)) u_sync (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .sig_async(carrier_in),
        .rise_p   (rise_p)
    );

    cpd_interval_timer #(.CNT_W(CPD_CNT_W), .WIN_LO(CPD_WIN_LO)) u_timer (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .rise_p   (rise_p),
        .in_window(in_window),
        .timeout_p(timeout_p),
        .armed    (armed),
        .count    (count)
    );

    cpd_verdict u_verdict (
        .clk_ref  (clk_ref),
        .rst_n    (rst_n),
        .rise_p   (rise_p),
        .in_window(in_window),
        .timeout_p(timeout_p),
        .present  (carrier_ok)
    );
endmodule

// File: rtl/cpd_checker.sv
// Temporal checks on the detector, attached to the top module by bind.
module cpd_checker #(
    parameter int unsigned CNT_W  = 4,
    parameter int unsigned WIN_LO = 14
) (
    input logic             clk_ref,
    input logic             rst_n,
    input logic             rise_p,
    input logic             armed,
    input logic [CNT_W-1:0] count,
    input logic             carrier_ok
);
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CLO  = CNT_W'(WIN_LO);

    // R2
    edge_pulse_width_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        rise_p |=> !rise_p);
    // R3
    window_accept_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (rise_p && armed && count >= CLO) |=> carrier_ok);
    // R4
    short_reject_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (rise_p && armed && count < CLO) |=> (!carrier_ok && count == '0 && armed));
    // R5
    timeout_drop_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (armed && count == CMAX && !rise_p) |=> (!carrier_ok && !armed));
    // R6
    disarmed_idle_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!armed && !rise_p) |=> (!armed && $stable(count) && !carrier_ok));
    // R7
    first_edge_low_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (rise_p && !armed) |=> !carrier_ok);
    // R9
    hold_high_chk: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (carrier_ok && !rise_p && !(armed && count == CMAX)) |=> carrier_ok);
endmodule

bind carrier_period_detector cpd_checker #(
    .CNT_W (cpd_pkg::CPD_CNT_W),
    .WIN_LO(cpd_pkg::CPD_WIN_LO)
) u_cpd_checker (
    .clk_ref   (clk_ref),
    .rst_n     (rst_n),
    .rise_p    (rise_p),
    .armed     (armed),
    .count     (count),
    .carrier_ok(carrier_ok)
);

// File: tb/carrier_period_detector_tb.sv
module carrier_period_detector_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 100000;

    logic clk_ref = 1'b0;
    logic rst_n   = 1'b0;
    logic carrier_in = 1'b0;
    logic carrier_ok;

    int vectors = 0;
    int fails   = 0;
    string cur_req = "R1";
    logic started = 1'b0;
    logic done    = 1'b0;

    // Reference model state: input history and edge timing.
    bit hist[$] = '{0, 0, 0, 0};
    int elapsed = 0;
    bit m_armed = 0;
    bit m_ok    = 0;
    bit seen_high = 0;

    carrier_period_detector u_dut (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .carrier_in(carrier_in),
        .carrier_ok(carrier_ok)
    );

    always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

    // Behavioural model: an edge is acted on two clocks after it is sampled.
    always @(posedge clk_ref) begin
        bit e;
        hist.push_front(rst_n ? carrier_in : 1'b0);
        void'(hist.pop_back());
        e = hist[2] && !hist[3];
        if (!rst_n) begin
            m_armed = 0; m_ok = 0; elapsed = 0;
        end else if (e) begin
            m_ok = m_armed && (elapsed + 1 >= 15) && (elapsed + 1 <= 16);
            m_armed = 1; elapsed = 0;
        end else if (m_armed) begin
            elapsed++;
            if (elapsed >= 16) begin m_armed = 0; m_ok = 0; end
        end
        started = 1'b1;
    end

    // Compare against the model away from the active edge.
    always @(negedge clk_ref) begin
        if (started && !done) begin
            vectors++;
            if (carrier_ok) seen_high = 1;
            if (carrier_ok !== m_ok) begin
                fails++;
                $display("FAIL %s: carrier_ok=%b expected %b at %0t", cur_req, carrier_ok, m_ok, $time);
            end
        end
    end

    task automatic check(input string req, input bit act, input bit exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        carrier_in = 1'b0;
        repeat (n) @(negedge clk_ref);
    endtask

    task automatic burst(input int period, input int high, input int count);
        for (int i = 0; i < count; i++) begin
            carrier_in = 1'b1;
            repeat (high) @(negedge clk_ref);
            carrier_in = 1'b0;
            repeat (period - high) @(negedge clk_ref);
        end
    endtask

    initial begin
        fork
            begin
                repeat (WATCHDOG) @(posedge clk_ref);
                fails++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
            begin
                // R1: reset state
                cur_req = "R1";
                repeat (5) @(negedge clk_ref);
                check("R1", carrier_ok, 1'b0);
                rst_n = 1'b1;
                idle(5);

                // R7: lone first edge leaves output low
                cur_req = "R7";
                burst(15, 7, 1);
                check("R7", carrier_ok, 1'b0);
                idle(30);

                // R3 R9 R2: valid 15-clock burst, then R5 timeout
                cur_req = "R3"; seen_high = 0;
                burst(15, 7, 6);
                check("R3", seen_high, 1'b1);
                check("R9", carrier_ok, 1'b1);
                cur_req = "R5";
                idle(16);
                check("R5", carrier_ok, 1'b0);
                idle(10);

                // R3: 16-clock periods also valid
                cur_req = "R3";
                burst(16, 8, 5);
                check("R3", carrier_ok, 1'b1);

                // R4: too-fast input drops the flag and stays low
                cur_req = "R4"; seen_high = 0;
                burst(12, 6, 8);
                check("R4", carrier_ok, 1'b0);
                idle(30);
                burst(14, 7, 6);
                check("R4", carrier_ok, 1'b0);
                idle(30);

                // R6: slow input and 17-clock periods always time out
                cur_req = "R6"; seen_high = 0;
                burst(20, 10, 6);
                burst(17, 8, 6);
                check("R6", seen_high, 1'b0);
                idle(30);

                // R8: duty cycle extremes
                cur_req = "R8";
                burst(15, 1, 4);
                check("R8", carrier_ok, 1'b1);
                burst(15, 14, 4);
                check("R8", carrier_ok, 1'b1);

                // R4 R9: a short interval inside a valid run, then recovery
                cur_req = "R4";
                burst(14, 7, 1);
                burst(15, 7, 1);
                burst(15, 7, 3);
                check("R9", carrier_ok, 1'b1);
                idle(40);
                done = 1'b1;
            end
        join_any
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule